// File: doc/BRIEF.md
# Five-Channel Down-Counting Interval Timer

This block holds five independent interval timers behind one simple register bus. Each channel has a count buffer, a compare buffer and a down-counter. All five channels share one packed control word. Software first writes a channel's count buffer. It then sets that channel's load-request bit, which copies the buffer into the counter. Last, it sets the run bit and clears the load-request bit in the same write, and picks periodic or single-shot operation with the repeat bit.

Once running, a channel moves one step down on each cycle in which its own tick-enable input is high. A count buffer value of N-1 gives one expiry every N ticks. On expiry the channel sends a one-cycle pulse on its own interrupt line. In periodic mode the counter then reloads from the count buffer. In single-shot mode the counter holds at zero until the next load request.

Each channel has a read-only observation register that shows the live counter value. A free-running timestamp that counts up is the bitwise inverse of that value.

Top module: `dntmr_top`

## Requirements
- R1: After reset the control word reads 0, every observation register reads 0 and all five interrupt lines are low.
- R2: The control word is at offset 0x08. Channel n's field starts at bit 0, 8, 12, 16 or 20 for n = 0..4. Within a field, run is the field's bit 0 and load-request is its bit 1. Repeat is the field's bit 3 for channels 0-3 and bit 2 for channel 4, which has a three-bit field. All other bits ignore writes and read 0, so writing all ones reads back 0x007BBB0B.
- R3: While a channel's load-request bit is set, its counter takes the count buffer value on every cycle and does not count, even when run and tick are both high.
- R4: A started single-shot channel whose counter was loaded with N-1 pulses its interrupt once on the N-th tick. It then holds its counter at 0 and pulses no more on later ticks.
- R5: With repeat set, the tick on which the channel expires reloads the counter from the count buffer. The channel then pulses its interrupt once every N ticks.
- R6: A tick advances only a started channel. Clearing run freezes that counter's value, and the rest of the control word keeps what was written.
- R7: Rewriting a count buffer while its channel is counting leaves the running count alone. The new value takes effect at the next reload or load request.
- R8: Interrupt bit n belongs to channel n only. Each expiry makes a pulse one cycle wide, seen in the cycle after the expiring tick.
- R9: Channel n's count buffer, compare buffer and observation register are at 0x0C+0x0C*n, 0x10+0x0C*n and 0x14+0x0C*n for n = 0..3. For channel 4 they are at 0x3C, 0x44 and 0x40. Both buffers read back what was written. Writes to an observation register are ignored.
- R10: Counters are 32 bits wide. Loading all ones and ticking once gives 0xFFFFFFFE, whose inverse is 1 and grows by one per tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address, for both write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_en | input | 5 | Per-channel count-step enable |
| irq | output | 5 | Per-channel expiry pulse |

## Verification
The case hardest to reach from the ports is a buffer rewrite in the middle of a count. It needs a channel that is already running with a known value and a bus write landing between two ticks. The bench gets there by ticking one step, writing the buffer, then ticking to expiry. It then checks that the old count ran out and that only the reload took the new value. The frozen-counter case is reached the same way: the bench clears run while the repeat bit stays set, then drives ticks on every channel.

// File: rtl/dntmr_pkg.sv
package dntmr_pkg;
   localparam int NUM_CH  = 5;
   localparam int CTRL_AD = 8'h08;

   // Bit position of the low end of a channel's control field.
   function automatic int fld_base(input int ch);
      return (ch == 0) ? 0 : 4 + 4 * ch;
   endfunction

   // Field width: the last channel has a narrower field.
   function automatic int fld_width(input int ch);
      return (ch == NUM_CH - 1) ? 3 : 4;
   endfunction

   function automatic int rpt_off(input int ch);
      return fld_width(ch) - 1;
   endfunction

   function automatic logic [31:0] ctrl_mask();
      logic [31:0] m;
      m = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         m[fld_base(c)]              = 1'b1;
         m[fld_base(c) + 1]          = 1'b1;
         m[fld_base(c) + rpt_off(c)] = 1'b1;
      end
      return m;
   endfunction

   function automatic int buf_ad(input int ch);
      return (ch < 4) ? 'h0C + 'h0C * ch : 'h3C;
   endfunction

   function automatic int cmp_ad(input int ch);
      return (ch < 4) ? 'h10 + 'h0C * ch : 'h44;
   endfunction

   function automatic int obs_ad(input int ch);
      return (ch < 4) ? 'h14 + 'h0C * ch : 'h40;
   endfunction
endpackage

// File: rtl/dntmr_chan.sv
module dntmr_chan #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             ld_req,
   input  logic             rpt,
   input  logic             tick,
   input  logic [CNT_W-1:0] cbuf,
   output logic [CNT_W-1:0] cnt_o,
   output logic             irq_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             spent_q;
   logic             step;
   logic             expire;

   always_comb begin
      step   = tick && run && !ld_req && !spent_q;
      expire = step && (cnt_q == '0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         spent_q <= 1'b0;
         irq_o   <= 1'b0;
      end else begin
         irq_o <= expire;
         if (ld_req) begin
            cnt_q   <= cbuf;
            spent_q <= 1'b0;
         end else if (step) begin
            if (cnt_q == '0) begin
               if (rpt) cnt_q <= cbuf;
               else     spent_q <= 1'b1;
            end else begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   end

   assign cnt_o = cnt_q;

   a_r3_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ld_req |=> (cnt_q == $past(cbuf)));

   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !ld_req) |=> $stable(cnt_q));

   a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(tick) && $past(run)));

   a_r4_spent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (spent_q && !ld_req) |=> !irq_o);

   a_r5_reload_val: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && $past(rpt)) |-> (cnt_q == $past(cbuf)));
endmodule

// File: rtl/dntmr_regs.sv
module dntmr_regs
   import dntmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   output logic [BUS_W-1:0]  rdata,
   input  logic [CNT_W-1:0]  cnt_obs [NUM_CH],
   output logic [CNT_W-1:0]  cbuf    [NUM_CH],
   output logic [NUM_CH-1:0] run,
   output logic [NUM_CH-1:0] ld_req,
   output logic [NUM_CH-1:0] rpt
);
   localparam logic [31:0] MASK = ctrl_mask();

   logic [31:0]      ctrl_q;
   logic [CNT_W-1:0] cbuf_q [NUM_CH];
   logic [CNT_W-1:0] cmp_q  [NUM_CH];

   always_ff @(posedge clk) begin
      if (!rst_n) ctrl_q <= '0;
      else if (we && addr == ADDR_W'(CTRL_AD)) ctrl_q <= 32'(wdata) & MASK;
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cbuf_q[c] <= '0;
            cmp_q[c]  <= '0;
         end else if (we) begin
            if (addr == ADDR_W'(buf_ad(c))) cbuf_q[c] <= wdata[CNT_W-1:0];
            if (addr == ADDR_W'(cmp_ad(c))) cmp_q[c]  <= wdata[CNT_W-1:0];
         end
      end
      assign cbuf[c]   = cbuf_q[c];
      assign run[c]    = ctrl_q[fld_base(c)];
      assign ld_req[c] = ctrl_q[fld_base(c) + 1];
      if (fld_width(c) == 3) begin : g_narrow
         assign rpt[c] = ctrl_q[fld_base(c) + 2];
      end else begin : g_wide
         assign rpt[c] = ctrl_q[fld_base(c) + 3];
      end
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(CTRL_AD)) rdata = BUS_W'(ctrl_q);
      for (int c = 0; c < NUM_CH; c++) begin
         if (addr == ADDR_W'(buf_ad(c))) rdata = BUS_W'(cbuf_q[c]);
         if (addr == ADDR_W'(cmp_ad(c))) rdata = BUS_W'(cmp_q[c]);
         if (addr == ADDR_W'(obs_ad(c))) rdata = BUS_W'(cnt_obs[c]);
      end
   end

   a_r2_undef_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (we && addr == ADDR_W'(CTRL_AD)) |=> ((ctrl_q & ~MASK) == '0));
endmodule

// File: rtl/dntmr_top.sv
module dntmr_top
   import dntmr_pkg::*;
#(
   parameter int CNT_W  = 32,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NUM_CH-1:0] tick_en,
   output logic [NUM_CH-1:0] irq
);
   if (CNT_W < 2 || CNT_W > BUS_W) begin : g_bad_cnt
      $error("dntmr_top: CNT_W must lie in 2..BUS_W");
   end
   if (BUS_W < 32) begin : g_bad_bus
      $error("dntmr_top: control word needs BUS_W >= 32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("dntmr_top: address map needs ADDR_W >= 7");
   end

   logic [CNT_W-1:0]  cnt_w  [NUM_CH];
   logic [CNT_W-1:0]  cbuf_w [NUM_CH];
   logic [NUM_CH-1:0] run_w, ld_w, rpt_w;

   dntmr_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .rdata   (bus_rdata),
      .cnt_obs (cnt_w),
      .cbuf    (cbuf_w),
      .run     (run_w),
      .ld_req  (ld_w),
      .rpt     (rpt_w)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      dntmr_chan #(.CNT_W(CNT_W)) u_chan (
         .clk    (clk),
         .rst_n  (rst_n),
         .run    (run_w[c]),
         .ld_req (ld_w[c]),
         .rpt    (rpt_w[c]),
         .tick   (tick_en[c]),
         .cbuf   (cbuf_w[c]),
         .cnt_o  (cnt_w[c]),
         .irq_o  (irq[c])
      );
   end
endmodule

// File: tb/dntmr_top_bench.sv
module dntmr_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [4:0]  tick_en = '0;
   logic [4:0]  irq;
   logic [4:0]  irq_s;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   dntmr_top u_dntmr_top (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_en(tick_en), .irq(irq)
   );

   // Address map and control bits as stated in R2 and R9.
   function automatic logic [7:0] a_buf(input int c); return (c < 4) ? 8'(12 + 12*c) : 8'h3C; endfunction
   function automatic logic [7:0] a_cmp(input int c); return (c < 4) ? 8'(16 + 12*c) : 8'h44; endfunction
   function automatic logic [7:0] a_obs(input int c); return (c < 4) ? 8'(20 + 12*c) : 8'h40; endfunction
   function automatic int fb(input int c); return (c == 0) ? 0 : 4 + 4*c; endfunction
   function automatic logic [31:0] b_run(input int c); return 32'(1) << fb(c); endfunction
   function automatic logic [31:0] b_ld(input int c);  return 32'(2) << fb(c); endfunction
   function automatic logic [31:0] b_rpt(input int c); return ((c == 4) ? 32'(4) : 32'(8)) << fb(c); endfunction

   localparam logic [7:0] A_CTRL = 8'h08;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic tick(input logic [4:0] m);
      @(negedge clk);
      tick_en = m;
      @(negedge clk);
      tick_en = '0;
      irq_s = irq;
   endtask

   task automatic arm(input int c, input logic [31:0] v, input logic rp);
      wr(a_buf(c), v);
      wr(A_CTRL, b_ld(c));
      wr(A_CTRL, b_run(c) | (rp ? b_rpt(c) : 32'(0)));
   endtask

   // Vector table: channel, buffer, repeat, ticks, expected pulses, expected count.
   localparam int V_N = 6;
   localparam int           V_CH [V_N] = '{0, 1, 2, 3, 4, 0};
   localparam logic [31:0]  V_BUF[V_N] = '{4, 4, 2, 0, 6, 1};
   localparam bit           V_RP [V_N] = '{0, 0, 1, 1, 1, 0};
   localparam int           V_TK [V_N] = '{5, 3, 9, 4, 10, 6};
   localparam int           V_IRQ[V_N] = '{1, 0, 3, 4, 1, 1};
   localparam logic [31:0]  V_OBS[V_N] = '{0, 1, 2, 0, 3, 0};

   initial begin
      #2_000_000;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(A_CTRL, d); chk("R1 ctrl", d, 0);
      for (int c = 0; c < 5; c++) begin rd(a_obs(c), d); chk("R1 obs", d, 0); end
      chk("R1 irq", 32'(irq), 0);

      // R2 packed control layout
      wr(A_CTRL, 32'hFFFF_FFFF); rd(A_CTRL, d); chk("R2 mask", d, 32'h007B_BB0B);
      wr(A_CTRL, 0); rd(A_CTRL, d); chk("R2 clear", d, 0);

      // R9 address map
      for (int c = 0; c < 5; c++) begin
         wr(a_buf(c), 32'h100 + 32'(c));
         wr(a_cmp(c), 32'hA00 + 32'(c));
      end
      for (int c = 0; c < 5; c++) begin
         rd(a_buf(c), d); chk("R9 cbuf", d, 32'h100 + 32'(c));
         rd(a_cmp(c), d); chk("R9 cmp", d, 32'hA00 + 32'(c));
      end
      wr(8'h14, 32'h5555); rd(8'h14, d); chk("R9 obs ro", d, 0);

      // Table walk: R4, R5, R8 per channel
      for (int v = 0; v < V_N; v++) begin
         int mine, other;
         mine = 0; other = 0;
         arm(V_CH[v], V_BUF[v], V_RP[v]);
         for (int t = 0; t < V_TK[v]; t++) begin
            tick(5'(1) << V_CH[v]);
            mine  += int'(irq_s[V_CH[v]]);
            other += $countones(irq_s) - int'(irq_s[V_CH[v]]);
         end
         chk("R5 pulses", 32'(mine), 32'(V_IRQ[v]));
         chk("R8 other lines", 32'(other), 0);
         rd(a_obs(V_CH[v]), d); chk("R4 count", d, V_OBS[v]);
         wr(A_CTRL, 0);
      end

      // R3 load request holds the counter
      wr(a_buf(1), 9); wr(A_CTRL, b_ld(1));
      rd(a_obs(1), d); chk("R3 load", d, 9);
      wr(A_CTRL, b_ld(1) | b_run(1));
      tick(5'b00010); tick(5'b00010);
      rd(a_obs(1), d); chk("R3 hold", d, 9);
      wr(A_CTRL, b_run(1)); tick(5'b00010);
      rd(a_obs(1), d); chk("R3 count", d, 8);

      // R6 halt keeps value and other bits
      arm(2, 5, 1'b1); tick(5'b00100); tick(5'b00100);
      rd(a_obs(2), d); chk("R6 run", d, 3);
      wr(A_CTRL, b_rpt(2)); rd(A_CTRL, d); chk("R6 ctrl", d, b_rpt(2));
      for (int t = 0; t < 3; t++) begin tick(5'b11111); chk("R6 no irq", 32'(irq_s), 0); end
      rd(a_obs(2), d); chk("R6 frozen", d, 3);

      // R7 buffer rewrite mid-count, single-shot, then R4 quiet after expiry
      arm(0, 3, 1'b0); tick(5'b00001);
      rd(a_obs(0), d); chk("R7 step", d, 2);
      wr(a_buf(0), 10);
      tick(5'b00001); tick(5'b00001);
      rd(a_obs(0), d); chk("R7 old count", d, 0);
      tick(5'b00001); chk("R7 expiry", 32'(irq_s), 1);
      tick(5'b00001); chk("R4 quiet", 32'(irq_s), 0);
      tick(5'b00001); chk("R4 quiet2", 32'(irq_s), 0);
      rd(a_obs(0), d); chk("R4 held", d, 0);

      // R7 rewrite with repeat: reload takes new value (R5)
      arm(0, 2, 1'b1); tick(5'b00001);
      wr(a_buf(0), 7);
      tick(5'b00001); chk("R7 no early", 32'(irq_s), 0);
      tick(5'b00001); chk("R5 expiry", 32'(irq_s), 1);
      rd(a_obs(0), d); chk("R7 new reload", d, 7);
      wr(A_CTRL, 0);

      // R10 full width and inverted timestamp
      arm(3, 32'hFFFF_FFFF, 1'b1); tick(5'b01000);
      rd(a_obs(3), d); chk("R10 count", d, 32'hFFFF_FFFE);
      chk("R10 stamp", ~d, 1);
      tick(5'b01000); rd(a_obs(3), d); chk("R10 stamp2", ~d, 2);
      wr(A_CTRL, 0);

      // R8 pulse width on the last channel
      arm(4, 0, 1'b1); tick(5'b10000);
      chk("R8 line4", 32'(irq_s), 32'h10);
      @(negedge clk); chk("R8 width", 32'(irq), 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule